// File: doc/BRIEF.md
# Event Frame Formatter to Buffer RAM

This block turns the data words of each triggered event into a framed record in an on-chip buffer memory while the beam burst is active. A record starts with three header words: the record length and burst number, the event number, and the arrival timestamp. The payload words follow in arrival order. Three trailer words close the record: a fixed marker, the readout duration, and a word that holds the data count and the error flags. Records are packed back to back from address 0 at every burst start.

The total record length is only known after the last payload word. For this reason the first header word is written with a zero length at the trigger, and it is written again with the final length as the last write of the record. If the buffer cannot hold all payload words, the surplus words are dropped, an overflow flag is set and the trailer is still written inside the buffer. When the burst ends and the block is idle, the next free address is presented as a fill count. During the interburst the host reads the records through a synchronous read port.

Top module: `evt_frame_writer`

## Requirements
- R1: Header layout at the record base address `b`. Word b holds the burst number in bits [31:16] and the total record length in words in bits [15:0]. Word b+1 holds the event number. Word b+2 holds a free-running cycle count sampled in the trigger cycle, so the difference between the timestamps of two records equals the number of cycles between their triggers.
- R2: Payload word k (k = 1..N, in arrival order) is stored at b+2+k. Only cycles with `dv_i` high while an event is open count as payload words.
- R3: The trailer follows the last stored payload word. The first trailer word is the marker 32'hEE0F_5A5A. The second is the readout time. The third holds the overflow flag in bit 31, bits [30:24] zero, the OR of `derr_i` over all payload cycles in bits [23:16], and the number of stored payload words in bits [15:0].
- R4: The length field is written as 0 at the trigger. The last write of the record puts the final length N+6 into it.
- R5: Each rising edge of `burst_i` increments the burst number (it is 0 after reset, so the first burst is 1) and sets the event number back to 0. Each accepted trigger takes the current event number and then increments it.
- R6: The readout time is the number of cycles from the trigger cycle to the cycle of the payload word marked by `dlast_i`.
- R7: A payload word is stored only while its address is below DEPTH-3. A word that arrives later is dropped and sets the overflow flag. The trailer is always written, so a record never goes past the end of the buffer.
- R8: A trigger is ignored while the burst is off (and in the first cycle of a burst), while a record is being written, or when fewer than 6 buffer words are free.
- R9: The first record of a burst starts at address 0. Each further record starts right after the previous one.
- R10: One cycle after the block is idle with the burst off following a burst, `fill_valid_o` is high and `fill_words_o` equals the next free address. `fill_valid_o` goes low within two cycles after `burst_i` rises.
- R11: `dv_i` has no effect while no event is open: nothing is written and the addresses do not advance.
- R12: After reset, `busy_o` and `fill_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_i | input | 1 | High during the beam burst |
| trig_i | input | 1 | Event trigger, one cycle |
| dv_i | input | 1 | Payload word valid |
| dlast_i | input | 1 | Marks the last payload word (taken with dv_i) |
| data_i | input | 32 | Payload word |
| derr_i | input | 8 | Detector error flags for the current word |
| rd_addr_i | input | ADDR_W | Host read address |
| rd_data_o | output | 32 | Host read data, one cycle after the address |
| busy_o | output | 1 | A record is being written |
| fill_valid_o | output | 1 | Fill count is valid (burst over, idle) |
| fill_words_o | output | ADDR_W+1 | Next free buffer address after the burst |

## Verification
The case that is hardest to reach from the ports is a record that runs into the end of the buffer. In that case the payload is cut, the flag is set, and the trailer lands in the last three words while a following trigger must be refused for lack of room. The bench builds the design with a 64-word buffer, starts a fresh burst, and sends one event of 70 words. It then reads back the last stored payload word and the three trailer words at the top of the memory, and it sends one more trigger to check that no record is started.

// File: rtl/efw_pkg.sv
package efw_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PAY, S_TR0, S_TR1, S_TR2, S_HD1, S_HD2, S_HD0
  } fmt_state_t;

  localparam logic [31:0] TRAILER_MARK = 32'hEE0F_5A5A;
  localparam int HDR_WORDS = 3;
  localparam int TRL_WORDS = 3;
  localparam int FRAME_OVH = HDR_WORDS + TRL_WORDS;
  localparam int ERR_W     = 8;
  localparam int LEN_W     = 16;
  localparam int BNUM_W    = 16;
endpackage

// File: rtl/efw_timebase.sv
module efw_timebase
  import efw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_i,
  input  logic              evt_take,
  output logic [31:0]       tnow,
  output logic              burst_act,
  output logic              burst_start,
  output logic [BNUM_W-1:0] burst_no,
  output logic [31:0]       evt_no
);
  logic burst_q;

  assign burst_act   = burst_q;
  assign burst_start = burst_i & ~burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tnow     <= '0;
      burst_q  <= 1'b0;
      burst_no <= '0;
      evt_no   <= '0;
    end else begin
      tnow    <= tnow + 32'd1;
      burst_q <= burst_i;
      if (burst_start) begin
        burst_no <= burst_no + 1'b1;
        evt_no   <= '0;
      end else if (evt_take) begin
        evt_no <= evt_no + 32'd1;
      end
    end
  end
endmodule

// File: rtl/efw_ram.sv
module efw_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/efw_seq.sv
module efw_seq
  import efw_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_act,
  input  logic              burst_start,
  input  logic [BNUM_W-1:0] burst_no,
  input  logic [31:0]       evt_no,
  input  logic [31:0]       tnow,
  input  logic              trig_i,
  input  logic              dv_i,
  input  logic              dlast_i,
  input  logic [31:0]       data_i,
  input  logic [ERR_W-1:0]  derr_i,
  output logic              evt_take,
  output logic              busy_o,
  output logic              fill_valid_o,
  output logic [AW:0]       fill_words_o,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [31:0]       wdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] TRIG_LIM = (AW+1)'(DEPTH - FRAME_OVH);
  localparam logic [AW:0] PAY_LIM  = (AW+1)'(DEPTH - TRL_WORDS);

  fmt_state_t        state;
  logic [AW:0]       ptr;
  logic [AW:0]       base;
  logic [AW:0]       pay_ptr;
  logic [31:0]       t_start;
  logic [31:0]       dur;
  logic [31:0]       evt_cur;
  logic [LEN_W-1:0]  ndata;
  logic [ERR_W-1:0]  err_acc;
  logic              ovf;
  logic              had_burst;
  logic [AW:0]       rec_len;

  assign evt_take = (state == S_IDLE) && burst_act && trig_i && (ptr <= TRIG_LIM);
  assign busy_o   = (state != S_IDLE);
  assign rec_len  = pay_ptr - base;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      ptr          <= '0;
      base         <= '0;
      pay_ptr      <= '0;
      t_start      <= '0;
      dur          <= '0;
      evt_cur      <= '0;
      ndata        <= '0;
      err_acc      <= '0;
      ovf          <= 1'b0;
      had_burst    <= 1'b0;
      fill_valid_o <= 1'b0;
      fill_words_o <= '0;
      we_o         <= 1'b0;
      waddr_o      <= '0;
      wdata_o      <= '0;
    end else begin
      we_o         <= 1'b0;
      fill_valid_o <= had_burst && !burst_act && (state == S_IDLE);
      fill_words_o <= ptr;
      case (state)
        S_IDLE: begin
          if (burst_start) begin
            ptr       <= '0;
            had_burst <= 1'b1;
          end else if (evt_take) begin
            base    <= ptr;
            pay_ptr <= ptr + (AW+1)'(HDR_WORDS);
            t_start <= tnow;
            evt_cur <= evt_no;
            ndata   <= '0;
            err_acc <= '0;
            ovf     <= 1'b0;
            we_o    <= 1'b1;
            waddr_o <= ptr[AW-1:0];
            wdata_o <= {burst_no, {LEN_W{1'b0}}};
            state   <= S_PAY;
          end
        end
        S_PAY: begin
          if (dv_i) begin
            err_acc <= err_acc | derr_i;
            if (pay_ptr < PAY_LIM) begin
              we_o    <= 1'b1;
              waddr_o <= pay_ptr[AW-1:0];
              wdata_o <= data_i;
              pay_ptr <= pay_ptr + 1'b1;
              ndata   <= ndata + 1'b1;
            end else begin
              ovf <= 1'b1;
            end
            if (dlast_i) begin
              dur   <= tnow - t_start;
              state <= S_TR0;
            end
          end
        end
        S_TR0: begin
          we_o    <= 1'b1;
          waddr_o <= pay_ptr[AW-1:0];
          wdata_o <= TRAILER_MARK;
          pay_ptr <= pay_ptr + 1'b1;
          state   <= S_TR1;
        end
        S_TR1: begin
          we_o    <= 1'b1;
          waddr_o <= pay_ptr[AW-1:0];
          wdata_o <= dur;
          pay_ptr <= pay_ptr + 1'b1;
          state   <= S_TR2;
        end
        S_TR2: begin
          we_o    <= 1'b1;
          waddr_o <= pay_ptr[AW-1:0];
          wdata_o <= {ovf, 7'b0, err_acc, ndata};
          pay_ptr <= pay_ptr + 1'b1;
          state   <= S_HD1;
        end
        S_HD1: begin
          we_o    <= 1'b1;
          waddr_o <= AW'(base + 1'b1);
          wdata_o <= evt_cur;
          state   <= S_HD2;
        end
        S_HD2: begin
          we_o    <= 1'b1;
          waddr_o <= AW'(base + 2'd2);
          wdata_o <= t_start;
          state   <= S_HD0;
        end
        S_HD0: begin
          we_o    <= 1'b1;
          waddr_o <= base[AW-1:0];
          wdata_o <= {burst_no, LEN_W'(rec_len)};
          ptr     <= pay_ptr;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_frame_writer.sv
module evt_frame_writer
  import efw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              burst_i,
  input  logic              trig_i,
  input  logic              dv_i,
  input  logic              dlast_i,
  input  logic [31:0]       data_i,
  input  logic [ERR_W-1:0]  derr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              busy_o,
  output logic              fill_valid_o,
  output logic [ADDR_W:0]   fill_words_o
);
  logic [31:0]       tnow;
  logic              burst_act;
  logic              burst_start;
  logic [BNUM_W-1:0] burst_no;
  logic [31:0]       evt_no;
  logic              evt_take;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [31:0]       mem_wd;

  efw_timebase u_tb (
    .clk(clk), .rst(rst), .burst_i(burst_i), .evt_take(evt_take),
    .tnow(tnow), .burst_act(burst_act), .burst_start(burst_start),
    .burst_no(burst_no), .evt_no(evt_no)
  );

  efw_seq #(.AW(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .burst_act(burst_act), .burst_start(burst_start),
    .burst_no(burst_no), .evt_no(evt_no), .tnow(tnow),
    .trig_i(trig_i), .dv_i(dv_i), .dlast_i(dlast_i), .data_i(data_i),
    .derr_i(derr_i), .evt_take(evt_take), .busy_o(busy_o),
    .fill_valid_o(fill_valid_o), .fill_words_o(fill_words_o),
    .we_o(mem_we), .waddr_o(mem_wa), .wdata_o(mem_wd)
  );

  efw_ram #(.AW(ADDR_W), .DW(32)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(rd_addr_i), .rdata(rd_data_o)
  );
endmodule

// File: rtl/efw_checker.sv
module efw_checker #(
  parameter int ADDR_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            burst_i,
  input logic            trig_i,
  input logic            busy_o,
  input logic            fill_valid_o,
  input logic [ADDR_W:0] fill_words_o,
  input logic            wr_en,
  input logic [31:0]     wr_data
);
  // R8: a record only starts on a trigger
  p_start_on_trig_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(trig_i));

  // R4: first write of a record carries a zero length
  p_placeholder_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (wr_en && wr_data[15:0] == 16'd0));

  // R4: last write of a record carries the final length
  p_len_patch_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (wr_en && wr_data[15:0] >= 16'd6));

  // R11: no memory write outside an open record
  p_write_in_record_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (busy_o || $past(busy_o)));

  // R10: fill count cleared once a burst begins
  p_fill_clear_r10: assert property (@(posedge clk) disable iff (rst)
    burst_i |-> ##2 !fill_valid_o);

  // R10: fill count steady while valid
  p_fill_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (fill_valid_o && $past(fill_valid_o)) |-> $stable(fill_words_o));
endmodule

bind evt_frame_writer efw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .burst_i(burst_i), .trig_i(trig_i),
  .busy_o(busy_o), .fill_valid_o(fill_valid_o), .fill_words_o(fill_words_o),
  .wr_en(mem_we), .wr_data(mem_wd)
);

// File: tb/evt_frame_writer_bench.sv
module evt_frame_writer_bench;
  localparam int AW = 6;
  localparam logic [31:0] MARK = 32'hEE0F_5A5A;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          burst_i = 1'b0;
  logic          trig_i = 1'b0;
  logic          dv_i = 1'b0;
  logic          dlast_i = 1'b0;
  logic [31:0]   data_i = '0;
  logic [7:0]    derr_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [31:0]   rd_data_o;
  logic          busy_o;
  logic          fill_valid_o;
  logic [AW:0]   fill_words_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int mark0, mark1, mark2;
  logic [31:0] ts0, ts1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_frame_writer #(.ADDR_W(AW)) u_evt_frame_writer (
    .clk(clk), .rst(rst), .burst_i(burst_i), .trig_i(trig_i), .dv_i(dv_i),
    .dlast_i(dlast_i), .data_i(data_i), .derr_i(derr_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o), .fill_valid_o(fill_valid_o),
    .fill_words_o(fill_words_o)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr_i = AW'(a);
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic send_event(input int n, input int gap, input int err_idx,
                            input logic [7:0] err_val, input logic [31:0] dbase,
                            input bit poke, output int mark);
    mark = cyc;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      dv_i = 1'b1;
      data_i = dbase + 32'(i);
      dlast_i = (i == n - 1);
      derr_i = (i == err_idx) ? err_val : 8'h00;
      @(negedge clk);
      dv_i = 1'b0;
      dlast_i = 1'b0;
      derr_i = 8'h00;
      if (i != n - 1) begin
        for (int g = 0; g < gap; g++) begin
          trig_i = poke;
          @(negedge clk);
          trig_i = 1'b0;
        end
      end
    end
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_record(input int b, input int bnum, input int evt, input int nstored,
                              input logic [31:0] dbase, input int dur, input logic [7:0] err,
                              input bit ovf, output logic [31:0] ts);
    logic [31:0] d;
    rd(b, d);
    chk("R1/R4 header length+burst", d, {16'(bnum), 16'(nstored + 6)});
    rd(b + 1, d);
    chk("R1/R5 event number", d, 32'(evt));
    rd(b + 2, ts);
    for (int k = 0; k < nstored; k++) begin
      rd(b + 3 + k, d);
      chk("R2 payload word", d, dbase + 32'(k));
    end
    rd(b + 3 + nstored, d);
    chk("R3 trailer marker", d, MARK);
    rd(b + 4 + nstored, d);
    chk("R6 readout time", d, 32'(dur));
    rd(b + 5 + nstored, d);
    chk("R3/R7 trailer status", d, {ovf, 7'b0, err, 16'(nstored)});
  endtask

  task automatic t_reset();
    chk("R12 busy after reset", 32'(busy_o), 0);
    chk("R12 fill_valid after reset", 32'(fill_valid_o), 0);
  endtask

  task automatic t_first_burst();
    logic [31:0] ts2;
    burst_i = 1'b1;
    repeat (3) @(negedge clk);
    send_event(4, 0, 1, 8'h05, 32'hA000_0000, 1'b0, mark0);
    check_record(0, 1, 0, 4, 32'hA000_0000, 4, 8'h05, 1'b0, ts0);
    // R11: stray valid words while no event is open
    dv_i = 1'b1; data_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    dv_i = 1'b0;
    chk("R11 no busy from stray data", 32'(busy_o), 0);
    // R8: a trigger during the gaps of this event must be ignored
    send_event(3, 1, 9, 8'h00, 32'hB000_0000, 1'b1, mark1);
    check_record(10, 1, 1, 3, 32'hB000_0000, 5, 8'h00, 1'b0, ts1);
    chk("R1 timestamp spacing", ts1 - ts0, 32'(mark1 - mark0));
    send_event(1, 0, 9, 8'h00, 32'hC000_0000, 1'b0, mark2);
    check_record(19, 1, 2, 1, 32'hC000_0000, 1, 8'h00, 1'b0, ts2);
  endtask

  task automatic t_burst_end();
    burst_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 fill_valid after burst", 32'(fill_valid_o), 1);
    chk("R9/R11 fill words after burst", 32'(fill_words_o), 26);
    // R8: trigger with the burst off
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    @(negedge clk);
    chk("R8 trigger ignored outside burst", 32'(busy_o), 0);
    chk("R8 fill words unchanged", 32'(fill_words_o), 26);
  endtask

  task automatic t_overflow_burst();
    logic [31:0] ts;
    int m;
    burst_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 fill_valid cleared in burst", 32'(fill_valid_o), 0);
    @(negedge clk);
    send_event(70, 0, 69, 8'h80, 32'hD000_0000, 1'b0, m);
    check_record(0, 2, 0, 58, 32'hD000_0000, 70, 8'h80, 1'b1, ts);
    // R8: buffer full, trigger refused
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    @(negedge clk);
    chk("R8 trigger refused when full", 32'(busy_o), 0);
    burst_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7/R10 fill words at top", 32'(fill_words_o), 64);
    chk("R10 fill_valid second burst", 32'(fill_valid_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_burst();
    t_burst_end();
    t_overflow_burst();
    report();
    $finish;
  end
endmodule